// File: doc/BRIEF.md
# Interrupt Holdoff and Enable Controller

This block drives the single level-sensitive interrupt request line towards the host. It combines three things: a pending summary produced elsewhere (status already masked), one global enable bit, and a holdoff timer. The timer keeps the line quiet for a programmed number of 100 µs ticks after software reads the interrupt status register. Software sets the enable bit and the holdoff settings through a small register port with a single write strobe. Reads of that port are combinational on the address.

The holdoff has two start modes. In immediate mode the countdown runs from the moment of the status read. In event mode the timer stays loaded and waits for the first pending interrupt, then counts down. This gives a fixed delay between the event and its report. A delay of zero turns the holdoff off. Each new status read reloads the timer and restarts the holdoff. The tick input is a one-cycle enable pulse from an outside prescaler. All control pins are plain levels or single-cycle pulses. No stream interface is involved, so there is no back-pressure.

Top module: `irq_holdoff_ctrl`

## Requirements
- R1: After reset, the register at byte offset 0x18 reads 0, the register at byte offset 0x1C reads 0, and `irq_o` is low.
- R2: Bit 0 of offset 0x18 is the global enable. It is read/write, and bits 31:1 always read as 0.
- R3: At offset 0x1C, bits 7:0 hold the delay count and bit 8 holds the start mode (1 = wait for event, 0 = start immediately). Both fields are read/write, and bits 31:9 always read as 0. Any other offset reads 0.
- R4: While the enable bit is 0, `irq_o` is low from the next clock onward, and a loaded countdown does not advance on ticks.
- R5: `irq_o` is registered. When the enable bit is 1 and no holdoff is active, `irq_o` follows `pend_any` one clock later.
- R6: In immediate mode with a nonzero delay N, an `isr_rd` pulse blocks `irq_o` from the second clock after the pulse. `irq_o` asserts again one clock after the Nth subsequent tick.
- R7: In event mode with a nonzero delay N, ticks that arrive before `pend_any` is seen with the enable bit at 1 are not counted. After the event, `irq_o` asserts one clock after the Nth tick.
- R8: With a delay of 0, an `isr_rd` pulse causes no holdoff in either mode.
- R9: An `isr_rd` pulse during a holdoff reloads the full delay. In event mode it also returns the timer to waiting for an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears both registers and the timer |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| pend_any | input | 1 | Masked pending-interrupt summary |
| isr_rd | input | 1 | One-cycle pulse marking a status register read |
| tick_100us | input | 1 | One-cycle prescaler pulse every 100 µs |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is a countdown that is already partly spent when another status read arrives. The bench has to prove that the timer went back to the full delay and not just that it kept running. It lets a few ticks pass, reads again, and then counts the exact number of ticks needed before `irq_o` returns. In event mode it holds `pend_any` high through the second read, so the timer re-arms and restarts in the same pass. The disabled case is handled the same way. The enable bit is cleared in the middle of a countdown, ticks are applied, and after re-enabling the bench counts the full remaining delay.

// File: rtl/irq_holdoff_pkg.sv
package irq_holdoff_pkg;
  typedef enum logic [1:0] {
    HO_IDLE  = 2'd0,
    HO_ARMED = 2'd1,
    HO_COUNT = 2'd2
  } ho_state_e;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8,
  parameter logic [ADDR_W-1:0] EN_OFFSET = 'h18,
  parameter logic [ADDR_W-1:0] HO_OFFSET = 'h1C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              en_q,
  output logic [CNT_W-1:0]  delay_q,
  output logic              mode_q
);
  localparam int MODE_BIT = CNT_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      delay_q <= '0;
      mode_q  <= 1'b0;
    end else if (wr_en) begin
      if (addr == EN_OFFSET) en_q <= wdata[0];
      if (addr == HO_OFFSET) begin
        delay_q <= wdata[CNT_W-1:0];
        mode_q  <= wdata[MODE_BIT];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == EN_OFFSET) begin
      rdata[0] = en_q;
    end else if (addr == HO_OFFSET) begin
      rdata[CNT_W-1:0] = delay_q;
      rdata[MODE_BIT]  = mode_q;
    end
  end
endmodule

// File: rtl/irq_holdoff_timer.sv
module irq_holdoff_timer
  import irq_holdoff_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] delay,
  input  logic             wait_evt,
  input  logic             load,
  input  logic             tick,
  input  logic             evt,
  output logic [CNT_W-1:0] cnt,
  output logic             idle,
  output logic             armed
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  ho_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (load) begin
      if (delay == '0) begin
        state_d = HO_IDLE;
        cnt_d   = '0;
      end else begin
        cnt_d   = delay;
        state_d = wait_evt ? HO_ARMED : HO_COUNT;
      end
    end else begin
      unique case (state_q)
        HO_ARMED: if (en && evt) state_d = HO_COUNT;
        HO_COUNT: if (en && tick) begin
          if (cnt_q <= ONE) begin
            cnt_d   = '0;
            state_d = HO_IDLE;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HO_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign cnt   = cnt_q;
  assign idle  = (state_q == HO_IDLE);
  assign armed = (state_q == HO_ARMED);
endmodule

// File: rtl/irq_out_gate.sv
module irq_out_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pend,
  input  logic hold_idle,
  output logic irq
);
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= en & pend & hold_idle;
  end

  assign irq = irq_q;
endmodule

// File: rtl/irq_holdoff_ctrl.sv
module irq_holdoff_ctrl #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8,
  parameter logic [ADDR_W-1:0] EN_OFFSET = 'h18,
  parameter logic [ADDR_W-1:0] HO_OFFSET = 'h1C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              pend_any,
  input  logic              isr_rd,
  input  logic              tick_100us,
  output logic              irq_o
);
  logic             en_q;
  logic [CNT_W-1:0] delay_q;
  logic             mode_q;
  logic [CNT_W-1:0] hold_cnt;
  logic             hold_idle;
  logic             hold_armed;

  irq_cfg_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .EN_OFFSET(EN_OFFSET), .HO_OFFSET(HO_OFFSET)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .en_q(en_q), .delay_q(delay_q), .mode_q(mode_q)
  );

  irq_holdoff_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(en_q), .delay(delay_q),
    .wait_evt(mode_q), .load(isr_rd), .tick(tick_100us), .evt(pend_any),
    .cnt(hold_cnt), .idle(hold_idle), .armed(hold_armed)
  );

  irq_out_gate u_gate (
    .clk(clk), .rst_n(rst_n), .en(en_q), .pend(pend_any),
    .hold_idle(hold_idle), .irq(irq_o)
  );
endmodule

// File: rtl/irq_holdoff_chk.sv
module irq_holdoff_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             isr_rd,
  input logic             pend_any,
  input logic             irq_o,
  input logic             en_q,
  input logic [CNT_W-1:0] delay_q,
  input logic [CNT_W-1:0] hold_cnt,
  input logic             hold_idle,
  input logic             hold_armed
);
  AST_IRQ_NEEDS_EN_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(en_q && pend_any)); // R5

  AST_NO_IRQ_IN_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(hold_idle)); // R6

  AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !isr_rd) |=> $stable(hold_cnt)); // R4

  AST_ARMED_NO_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_armed && !isr_rd) |=> $stable(hold_cnt)); // R7

  AST_ZERO_DELAY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_rd && delay_q == '0) |=> hold_idle); // R8

  AST_RELOAD_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_rd && delay_q != '0) |=> (hold_cnt == $past(delay_q) && !hold_idle)); // R9
endmodule

bind irq_holdoff_ctrl irq_holdoff_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .isr_rd(isr_rd), .pend_any(pend_any),
  .irq_o(irq_o), .en_q(en_q), .delay_q(delay_q), .hold_cnt(hold_cnt),
  .hold_idle(hold_idle), .hold_armed(hold_armed)
);

// File: tb/test_irq_holdoff_ctrl.sv
module test_irq_holdoff_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pend_any = 1'b0;
  logic        isr_rd = 1'b0;
  logic        tick_100us = 1'b0;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [7:0] A_EN = 8'h18;
  localparam logic [7:0] A_HO = 8'h1C;

  always #10 clk = ~clk;

  irq_holdoff_ctrl i_irq_holdoff_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pend_any(pend_any),
    .isr_rd(isr_rd), .tick_100us(tick_100us), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic do_reset();
    reg_we = 0; isr_rd = 0; tick_100us = 0; pend_any = 0;
    rst_n = 0;
    step(2);
    rst_n = 1;
    step(1);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    step(1);
    reg_we = 0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic isr_pulse();
    isr_rd = 1; step(1); isr_rd = 0;
  endtask

  task automatic tick_pulse();
    tick_100us = 1; step(1); tick_100us = 0;
  endtask

  task automatic t_reset();
    do_reset();
    rd_check("R1 en reg", A_EN, 32'h0);
    rd_check("R1 ho reg", A_HO, 32'h0);
    check("R1 irq", irq_o, 0);
  endtask

  task automatic t_regs();
    do_reset();
    wr(A_EN, 32'hFFFF_FFFF);
    rd_check("R2 en upper zero", A_EN, 32'h1);
    wr(A_EN, 32'hFFFF_FFFE);
    rd_check("R2 en clear", A_EN, 32'h0);
    wr(A_HO, 32'hFFFF_FFFF);
    rd_check("R3 ho all ones", A_HO, 32'h1FF);
    wr(A_HO, 32'h0000_00A5);
    rd_check("R3 ho count only", A_HO, 32'h0A5);
    rd_check("R3 other offset", 8'h20, 32'h0);
  endtask

  task automatic t_latency();
    do_reset();
    wr(A_EN, 1);
    pend_any = 1;
    check("R5 not combinational", irq_o, 0);
    step(1);
    check("R5 follows pend", irq_o, 1);
    pend_any = 0;
    step(1);
    check("R5 follows pend low", irq_o, 0);
    pend_any = 1;
    step(1);
    wr(A_EN, 0);
    step(1);
    check("R4 disable forces low", irq_o, 0);
  endtask

  task automatic t_immediate();
    do_reset();
    wr(A_HO, 32'h003);
    wr(A_EN, 1);
    pend_any = 1;
    step(1);
    check("R6 before read", irq_o, 1);
    isr_pulse();
    step(1);
    check("R6 blocked", irq_o, 0);
    tick_pulse(); tick_pulse();
    step(3);
    check("R6 after 2 ticks", irq_o, 0);
    tick_pulse();
    check("R6 edge of 3rd tick", irq_o, 0);
    step(1);
    check("R6 released", irq_o, 1);
  endtask

  task automatic t_event();
    do_reset();
    wr(A_HO, 32'h102);
    wr(A_EN, 1);
    isr_pulse();
    for (int i = 0; i < 4; i++) tick_pulse();
    pend_any = 1;
    step(4);
    check("R7 ticks before event ignored", irq_o, 0);
    tick_pulse();
    step(1);
    check("R7 after 1 tick", irq_o, 0);
    tick_pulse();
    step(1);
    check("R7 released", irq_o, 1);
  endtask

  task automatic t_zero();
    do_reset();
    wr(A_EN, 1);
    pend_any = 1;
    wr(A_HO, 32'h100);
    isr_pulse();
    step(1);
    check("R8 event mode no hold", irq_o, 1);
    wr(A_HO, 32'h000);
    isr_pulse();
    step(1);
    check("R8 immediate mode no hold", irq_o, 1);
  endtask

  task automatic t_disabled_hold();
    do_reset();
    wr(A_HO, 32'h002);
    wr(A_EN, 1);
    pend_any = 1;
    isr_pulse();
    wr(A_EN, 0);
    for (int i = 0; i < 5; i++) tick_pulse();
    wr(A_EN, 1);
    step(2);
    check("R4 count frozen while disabled", irq_o, 0);
    tick_pulse();
    step(1);
    check("R4 one tick left", irq_o, 0);
    tick_pulse();
    step(1);
    check("R4 released after full count", irq_o, 1);
  endtask

  task automatic t_reload();
    do_reset();
    wr(A_HO, 32'h003);
    wr(A_EN, 1);
    pend_any = 1;
    isr_pulse();
    tick_pulse(); tick_pulse();
    isr_pulse();
    tick_pulse(); tick_pulse();
    step(2);
    check("R9 immediate reload", irq_o, 0);
    tick_pulse();
    step(1);
    check("R9 immediate released", irq_o, 1);
    wr(A_HO, 32'h102);
    isr_pulse();
    step(1);
    tick_pulse();
    isr_pulse();
    step(1);
    tick_pulse();
    step(1);
    check("R9 event reload", irq_o, 0);
    tick_pulse();
    step(1);
    check("R9 event released", irq_o, 1);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_regs();
    t_latency();
    t_immediate();
    t_event();
    t_zero();
    t_disabled_hold();
    t_reload();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule